// File: doc/BRIEF.md
# Two-wire serial slave with broadcast and alert response

This block is the digital front end of the two-wire management bus on a multi-port power controller. It samples the bus clock and a data input through synchronizers. It finds START and STOP conditions and shifts address and data bytes. It drives a separate open-drain data output whose enable pin, when high, means "pull the line low". The device answers to a 7-bit address whose upper three bits are fixed at `010` and whose lower four bits come from strap pins, so sixteen devices can share one bus.

A host writes a pointer byte and then data bytes that go to successive registers. A repeated START followed by a read returns bytes from the pointer onward. Every device also takes writes sent to a shared broadcast address, so one transaction can program them all. An event register collects pulses from the controller core and drives an active-low interrupt output. While that output is low, the device answers the alert response address by sending its own address. This lets the host find out which device raised the interrupt.

The bus carries single bytes that are clocked by the master. It has no valid/ready stream, so every pin is a plain control or status signal. Back-pressure does not apply: the slave acknowledges or refuses each byte during the ninth clock.

Top module: `pse_bus_slave`

## Requirements
- R1: The device acknowledges address `{3'b010, strap_i[3:0]}` for both reads and writes. Any other address that is not the broadcast or alert address gets no acknowledge, and the strap value in force at the time of the address byte applies.
- R2: A write to broadcast address 0x30 is acknowledged and updates registers exactly as a write to the own address does.
- R3: A read to broadcast address 0x30 is not acknowledged.
- R4: Alert address 0x0C with the read bit is acknowledged only while `int_n` is low. The device then returns the byte `{own address, 1'b1}`. With the write bit, or while `int_n` is high, 0x0C is not acknowledged.
- R5: In a write, the first byte after the address loads the register pointer. Each further byte is written to the pointed register, and the pointer then advances by one. Registers 0x10 to 0x17 are read/write storage. A read returns the pointed register and advances the pointer for each byte.
- R6: After reset, register 0x17 reads 0x80 and registers 0x10 to 0x16 read 0x00. Bit 7 of 0x17 is the interrupt enable.
- R7: A high bit on `evt_set` sets the matching bit of the event register on the next clock. `int_n` is low exactly when the enable bit is 1 and at least one event bit is set. With the enable bit at 0, `int_n` stays high.
- R8: Reading register 0x00 returns the event bits and leaves them set. Reading register 0x01 returns the event bits and clears them, so `int_n` goes high.
- R9: Writing a byte with bit 7 set to register 0x1A clears all event bits. Register 0x1A and the addresses that are not mapped read as 0x00.
- R10: `sda_oe` is high only during acknowledge bits that the device gives and during 0-valued data bits that it sends. It is low whenever the bus is idle after a STOP.
- R11: A START, including a repeated START in the middle of a transfer, restarts the address phase. The pointer keeps its value across it.
- R12: A master NACK after a read byte ends the transfer: the device releases the data line, and the next START is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as received, asynchronous |
| strap_i | input | 4 | Low four bits of the device address |
| evt_set | input | 8 | One-clock pulses that set event bits |
| sda_oe | output | 1 | High to pull the data line low |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench aims at the decisions that are made during the address byte. One is an alert address that must be refused while the interrupt is idle or masked. Another is a broadcast read that must be refused, and a third is a strap change that must move the device's address. A design that got any of these wrong would acknowledge a byte meant for another device and pull the data line against that device. Further checks cover read-to-clear of the event register, the clear-all command, a pointer that must advance across a repeated START, and a master NACK. A design that mishandled these would leave the interrupt stuck low, return the wrong register, or keep driving data after the master has stopped reading.

// File: rtl/pse_i2c_pkg.sv
package pse_i2c_pkg;
  localparam logic [6:0] BCAST_ADDR = 7'h30;
  localparam logic [6:0] ALERT_ADDR = 7'h0C;
  localparam logic [2:0] ADDR_HI    = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_st_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_PTR,
    RX_DATA
  } rx_kind_t;
endpackage

// File: rtl/pse_line_sync.sv
module pse_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s && !scl_d;
  assign scl_fall  = !scl_s && scl_d;
  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
endmodule

// File: rtl/pse_bus_fsm.sv
module pse_bus_fsm
  import pse_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] own_addr,
  input  logic       int_active,
  input  logic [7:0] rd_data,
  output logic       wr_en,
  output logic       rd_en,
  output logic [7:0] reg_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  bus_st_t    st;
  rx_kind_t   kind;
  logic [3:0] cnt;
  logic [7:0] sh, ptr;
  logic       rw_q, ara_q, mack_q;
  logic       hit_own, hit_bc, hit_ara;

  // address decode on the completed first byte
  always_comb begin
    hit_own = (sh[7:1] == own_addr);
    hit_bc  = (sh[7:1] == BCAST_ADDR) && !sh[0];
    hit_ara = (sh[7:1] == ALERT_ADDR) && sh[0] && int_active;
  end

  assign reg_addr = ptr;
  assign wr_data  = sh;
  assign wr_en    = scl_fall && (st == ST_RX) && (kind == RX_DATA) && (cnt == 4'd8);
  assign rd_en    = scl_fall &&
                    (((st == ST_ACK) && (kind == RX_ADDR) && rw_q && !ara_q) ||
                     ((st == ST_MACK) && mack_q));
  assign sda_oe   = (st == ST_ACK) || ((st == ST_TX) && !sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind   <= RX_ADDR;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw_q   <= 1'b0;
      ara_q  <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_det) begin
      st   <= ST_RX;
      kind <= RX_ADDR;
      cnt  <= '0;
    end else if (stop_det) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            unique case (kind)
              RX_ADDR: begin
                if (hit_own || hit_bc || hit_ara) begin
                  st    <= ST_ACK;
                  rw_q  <= sh[0];
                  ara_q <= hit_ara;
                end else begin
                  st <= ST_IDLE;
                end
              end
              RX_PTR: begin
                ptr <= sh;
                st  <= ST_ACK;
              end
              default: begin
                ptr <= ptr + 8'd1;
                st  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (kind == RX_ADDR && rw_q) begin
              st  <= ST_TX;
              cnt <= '0;
              if (ara_q) begin
                sh <= {own_addr, 1'b1};
              end else begin
                sh  <= rd_data;
                ptr <= ptr + 8'd1;
              end
            end else begin
              st   <= ST_RX;
              kind <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= ST_MACK;
            end else begin
              sh  <= {sh[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= !sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st  <= ST_TX;
              sh  <= rd_data;
              ptr <= ptr + 8'd1;
              cnt <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pse_reg_file.sv
module pse_reg_file #(
  parameter int EVT_W       = 8,
  parameter int N_GP        = 8,
  parameter int GP_BASE     = 16,
  parameter int CFG_IDX     = 7,
  parameter int EVT_ADDR    = 0,
  parameter int EVT_RC_ADDR = 1,
  parameter int CMD_ADDR    = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       addr,
  input  logic [7:0]       wr_data,
  input  logic [EVT_W-1:0] evt_set,
  output logic [7:0]       rd_data,
  output logic             int_en,
  output logic [EVT_W-1:0] ev,
  output logic             int_active
);
  logic [7:0] gp [N_GP];
  logic       clr_all, clr_rd;

  genvar gi;
  generate
    for (gi = 0; gi < N_GP; gi++) begin : g_gp
      localparam logic [7:0] RST_VAL = (gi == CFG_IDX) ? 8'h80 : 8'h00;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gp[gi] <= RST_VAL;
        else if (wr_en && addr == 8'(GP_BASE + gi)) gp[gi] <= wr_data;
      end
    end
  endgenerate

  assign clr_all = wr_en && (addr == 8'(CMD_ADDR)) && wr_data[7];
  assign clr_rd  = rd_en && (addr == 8'(EVT_RC_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev <= '0;
    else if (clr_all || clr_rd) ev <= evt_set;
    else ev <= ev | evt_set;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_GP; i++) begin
      if (addr == 8'(GP_BASE + i)) rd_data = gp[i];
    end
    if (addr == 8'(EVT_ADDR) || addr == 8'(EVT_RC_ADDR)) rd_data[EVT_W-1:0] = ev;
  end

  assign int_en     = gp[CFG_IDX][7];
  assign int_active = int_en && (|ev);
endmodule

// File: rtl/pse_bus_slave.sv
module pse_bus_slave
  import pse_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EVT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [3:0]       strap_i,
  input  logic [EVT_W-1:0] evt_set,
  output logic             sda_oe,
  output logic             int_n
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en, rd_en, int_en, int_active;
  logic [7:0]       reg_addr, wr_data, rd_data;
  logic [EVT_W-1:0] ev;
  logic [6:0]       own_addr;

  assign own_addr = {ADDR_HI, strap_i};

  pse_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  pse_bus_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .int_active(int_active), .rd_data(rd_data),
    .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  pse_reg_file #(.EVT_W(EVT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(reg_addr),
    .wr_data(wr_data), .evt_set(evt_set), .rd_data(rd_data), .int_en(int_en),
    .ev(ev), .int_active(int_active)
  );

  assign int_n = !int_active;
endmodule

// File: rtl/pse_bus_slave_chk.sv
module pse_bus_slave_chk #(
  parameter int EVT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             int_n,
  input logic             int_en,
  input logic [EVT_W-1:0] evt_set
);
  assert_start_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_oe_stable_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  assert_int_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> int_en);

  assert_event_raises_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_set) && int_en) |=> (!int_n || !int_en));
endmodule

bind pse_bus_slave pse_bus_slave_chk #(.EVT_W(EVT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .int_n(int_n), .int_en(int_en),
  .evt_set(evt_set)
);

// File: tb/pse_bus_slave_tb_top.sv
module pse_bus_slave_tb_top;
  localparam int H  = 10;
  localparam int WD = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap = 4'b0101;
  logic [7:0] evt = '0;
  wire        sda_oe, int_n;
  wire        sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  pse_bus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .evt_set(evt), .sda_oe(sda_oe), .int_n(int_n)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit quiet = 0, done = 0;
  logic [7:0] m_gp [8];
  logic [7:0] m_ev = '0;

  function automatic logic [6:0] own();
    return {3'b010, strap};
  endfunction
  function automatic logic exp_int_n();
    return !(m_gp[7][7] && m_ev != 0);
  endfunction
  function automatic logic [7:0] m_read(input logic [7:0] p);
    if (p >= 8'h10 && p <= 8'h17) return m_gp[p - 8'h10];
    if (p == 8'h00 || p == 8'h01) return m_ev;
    return 8'h00;
  endfunction
  function automatic void m_write(input logic [7:0] p, input logic [7:0] d);
    if (p >= 8'h10 && p <= 8'h17) m_gp[p - 8'h10] = d;
    if (p == 8'h1A && d[7]) m_ev = '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // per-clock comparison against the model while the bus is idle
  always @(negedge clk) begin
    if (rst_n && quiet && !done) begin
      chk(int_n == exp_int_n(), "R7 int_n vs model", int_n, exp_int_n());
      chk(sda_oe == 1'b0, "R10 idle release", sda_oe, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      summary();
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wait_n(2); sda_m = b;
    wait_n(H); scl_m = 1'b1;
    wait_n(H); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wait_n(2); sda_m = 1'b1;
    wait_n(H); scl_m = 1'b1;
    wait_n(H/2); b = sda_line;
    wait_n(H/2); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    quiet = 0;
    wait_n(2); sda_m = 1'b1;
    wait_n(H); scl_m = 1'b1;
    wait_n(H); sda_m = 1'b0;
    wait_n(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(2); sda_m = 1'b0;
    wait_n(H); scl_m = 1'b1;
    wait_n(H); sda_m = 1'b1;
    wait_n(H);
    quiet = 1;
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv(output logic [7:0] b, input bit last);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(last);
  endtask

  task automatic wr_seq(input logic [6:0] a, input logic [7:0] p,
                        input logic [7:0] d [$], input string tag);
    bit ack;
    logic [7:0] pp = p;
    bus_start();
    send({a, 1'b0}, ack); chk(ack, {tag, " addr ack"}, ack, 1);
    send(p, ack);         chk(ack, {tag, " ptr ack"}, ack, 1);
    foreach (d[i]) begin
      send(d[i], ack);    chk(ack, {tag, " data ack"}, ack, 1);
      m_write(pp, d[i]);
      pp++;
    end
    bus_stop();
  endtask

  task automatic rd_seq(input logic [6:0] a, input logic [7:0] p, input int n,
                        input string tag, output logic [7:0] q [$]);
    bit ack;
    logic [7:0] b;
    q = {};
    bus_start();
    send({a, 1'b0}, ack); chk(ack, {tag, " addr ack"}, ack, 1);
    send(p, ack);         chk(ack, {tag, " ptr ack"}, ack, 1);
    bus_start();
    send({a, 1'b1}, ack); chk(ack, {tag, " read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(b, i == n - 1);
      q.push_back(b);
    end
    bus_stop();
  endtask

  task automatic probe(input logic [7:0] b, output bit ack);
    bus_start();
    send(b, ack);
    bus_stop();
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    quiet = 0;
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
    m_ev = m_ev | v;
    quiet = 1;
  endtask

  initial begin
    logic [7:0] q [$];
    logic [7:0] b;
    bit ack;
    for (int i = 0; i < 8; i++) m_gp[i] = (i == 7) ? 8'h80 : 8'h00;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    quiet = 1;
    chk(int_n == 1'b1, "R6 reset int_n", int_n, 1);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);

    // R6 reset values
    rd_seq(own(), 8'h16, 2, "R6", q);
    chk(q[0] == 8'h00, "R6 reg16 reset", q[0], 0);
    chk(q[1] == 8'h80, "R6 reg17 reset", q[1], 8'h80);

    // R5 write burst and read back, R12 NACK ending
    wr_seq(own(), 8'h10, '{8'hA5, 8'h3C, 8'h5A}, "R5 write");
    rd_seq(own(), 8'h10, 3, "R5 read", q);
    for (int i = 0; i < 3; i++)
      chk(q[i] == m_read(8'h10 + 8'(i)), "R5 readback", q[i], m_read(8'h10 + 8'(i)));
    wr_seq(own(), 8'h13, '{8'h0F}, "R12 after NACK");

    // R1 wrong address
    probe({7'h26, 1'b0}, ack); chk(!ack, "R1 foreign write nack", ack, 0);
    probe({7'h24, 1'b1}, ack); chk(!ack, "R1 foreign read nack", ack, 0);

    // R2 / R3 broadcast
    wr_seq(7'h30, 8'h12, '{8'h77}, "R2 bcast");
    rd_seq(own(), 8'h12, 1, "R2 check", q);
    chk(q[0] == 8'h77, "R2 bcast updated", q[0], 8'h77);
    probe({7'h30, 1'b1}, ack); chk(!ack, "R3 bcast read nack", ack, 0);

    // R4 alert response
    probe({7'h0C, 1'b1}, ack); chk(!ack, "R4 alert nack idle", ack, 0);
    pulse_evt(8'h05);
    wait_n(1);
    chk(int_n == 1'b0, "R7 int after event", int_n, 0);
    bus_start();
    send({7'h0C, 1'b1}, ack); chk(ack, "R4 alert ack", ack, 1);
    recv(b, 1'b1);
    chk(b == {own(), 1'b1}, "R4 alert returns own", b, {own(), 1'b1});
    bus_stop();
    probe({7'h0C, 1'b0}, ack); chk(!ack, "R4 alert write nack", ack, 0);

    // R8 event reads
    rd_seq(own(), 8'h00, 1, "R8 peek", q);
    chk(q[0] == 8'h05, "R8 peek value", q[0], 5);
    chk(int_n == 1'b0, "R8 peek keeps int", int_n, 0);
    rd_seq(own(), 8'h01, 1, "R8 take", q);
    chk(q[0] == 8'h05, "R8 take value", q[0], 5);
    m_ev = '0;
    chk(int_n == 1'b1, "R8 take clears int", int_n, 1);

    // R9 clear-all command
    pulse_evt(8'h42);
    wr_seq(own(), 8'h1A, '{8'h80}, "R9 clear");
    chk(int_n == 1'b1, "R9 int cleared", int_n, 1);
    rd_seq(own(), 8'h1A, 1, "R9 cmd read", q);
    chk(q[0] == 8'h00, "R9 cmd reads zero", q[0], 0);
    rd_seq(own(), 8'h00, 1, "R9 events zero", q);
    chk(q[0] == 8'h00, "R9 events cleared", q[0], 0);

    // R7 mask, R4 alert ignored while masked
    wr_seq(own(), 8'h17, '{8'h00}, "R7 mask");
    pulse_evt(8'h01);
    wait_n(1);
    chk(int_n == 1'b1, "R7 masked int high", int_n, 1);
    probe({7'h0C, 1'b1}, ack); chk(!ack, "R4 alert masked nack", ack, 0);
    wr_seq(own(), 8'h17, '{8'h80}, "R7 unmask");
    chk(int_n == 1'b0, "R7 unmasked int low", int_n, 0);
    wr_seq(own(), 8'h1A, '{8'h80}, "R9 clear2");

    // R11 repeated start keeps pointer
    bus_start();
    send({own(), 1'b0}, ack); chk(ack, "R11 addr", ack, 1);
    send(8'h11, ack);
    send(8'h99, ack); chk(ack, "R11 data", ack, 1);
    m_write(8'h11, 8'h99);
    bus_start();
    send({own(), 1'b1}, ack); chk(ack, "R11 reread addr", ack, 1);
    recv(b, 1'b1);
    chk(b == m_read(8'h12), "R11 pointer kept", b, m_read(8'h12));
    bus_stop();

    // R1 strap change
    strap = 4'b1010;
    wait_n(4);
    probe({7'h25, 1'b0}, ack); chk(!ack, "R1 old strap nack", ack, 0);
    probe({7'h2A, 1'b0}, ack); chk(ack, "R1 new strap ack", ack, 1);
    rd_seq(own(), 8'h11, 1, "R1 new strap read", q);
    chk(q[0] == 8'h99, "R1 new strap data", q[0], 8'h99);

    wait_n(20);
    summary();
    $finish;
  end
endmodule